// File: doc/BRIEF.md
# Comparator-Driven DAC Search Converter

This block is the digital controller of a direct-conversion analog-to-digital converter. The other two parts sit off the block: an RC low-pass filter that turns a pulse-width output into a DAC level, and a comparator that reports whether that level is above the unknown input. The controller holds the working code and drives the pulse train from it. It passes the comparator bit through a two-stage synchronizer. It then moves the code toward the input level by one of three search methods, which are picked per conversion.

Each conversion starts with a start pulse while the block is idle. Stair-step mode clears the code and waits a discharge time, then counts upward. Tracking mode starts from the code left by the last conversion and steps toward the input. Successive-approximation mode sets one bit per trial, from the most significant bit down. Every code change is followed by a programmable settle wait before the comparator is sampled. When a conversion ends, the result is published with a one-cycle done pulse. The code then stays where the search stopped, so the DAC output remains stable between conversions.

Top module: `adc_search_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `result_o` and `pwm_o` are all zero until a conversion is started.
- R2: The pulse output has a period of 2^DW clocks. In any 2^DW consecutive clocks during which the code is unchanged, `pwm_o` is high for exactly as many clocks as the code value.
- R3: Stair-step mode (`mode_i` = 0) sets the code to 0 and waits `discharge_i`+1 cycles. It then samples at codes 0, 1, 2, … and steps up by one after each low comparator reading. It stops at the first code where the comparator reads high. From the start edge to done, the conversion takes `discharge_i`+1 + k·(`settle_i`+2) cycles, where k is the number of samples.
- R4: A search never goes past the all-ones code 2^DW−1. In stair-step mode, and in tracking mode when moving up, reaching that code with the comparator still low ends the conversion with the all-ones result.
- R5: Tracking mode (`mode_i` = 1) keeps the previous code and has no discharge wait. It steps down after a high reading and up after a low one. It stops at the first sample whose reading differs from the first reading of the conversion, or at a code bound. It takes k·(`settle_i`+2) cycles for k samples.
- R6: Successive-approximation mode (`mode_i` = 2) makes exactly DW trials from the MSB down. Each trial drives the kept bits plus the trial bit, and the trial bit is kept when the comparator reads low. The conversion always takes DW·(`settle_i`+2) cycles.
- R7: After every code change, the comparator is not sampled until `settle_i`+1 clock cycles have passed. A sample uses the comparator input as seen through two clock stages.
- R8: The mode is captured on the cycle a conversion is accepted. Changes of `mode_i`, and further start pulses, while `busy_o` is high have no effect on that conversion.
- R9: `done_o` is high for exactly one cycle per conversion, and `busy_o` is low in that cycle. `result_o` changes only in the cycle `done_o` is high.
- R10: Mode code 3 behaves exactly like successive-approximation mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when idle |
| mode_i | input | 2 | Search method: 0 stair-step, 1 tracking, 2 or 3 successive approximation |
| settle_i | input | TW | Settle wait after each code change, in cycles (plus one) |
| discharge_i | input | TW | Discharge wait before a stair-step search, in cycles (plus one) |
| cmp_i | input | 1 | Asynchronous comparator output, high when the DAC level is above the input |
| pwm_o | output | 1 | Pulse-width DAC drive to the external RC filter |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is published |
| result_o | output | DW | Last conversion result |

## Verification
The assertions assume that the comparator is stable at the moment of sampling. In practice this means the settle time is at least one full PWM period plus the synchronizer delay, so the filtered level has reached the new code. The bench meets this by modelling the RC filter as the count of high pulses over the last 2^DW clocks and choosing settle values above 2^DW+1. It also keeps the input level and the settle and discharge values constant while a conversion runs, and changes only the mode and start inputs mid-conversion.

// File: rtl/adc_search_pkg.sv
package adc_search_pkg;

  typedef enum logic [1:0] {
    MODE_STAIR = 2'd0,
    MODE_TRACK = 2'd1,
    MODE_SAR   = 2'd2,
    MODE_SAR_X = 2'd3
  } srch_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DISCH  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_SAMPLE = 2'd3
  } srch_state_e;

endpackage

// File: rtl/adc_cmp_sync.sv
module adc_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/adc_pwm_dac.sv
module adc_pwm_dac #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] code_i,
  output logic          pwm_o
);

  logic [DW-1:0] phase_q;
  logic          pwm_q;

  // free-running phase, period 2^DW
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      phase_q <= phase_q + 1'b1;
      pwm_q   <= (phase_q < code_i);
    end
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/adc_search_fsm.sv
module adc_search_fsm
  import adc_search_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [TW-1:0] settle_i,
  input  logic [TW-1:0] discharge_i,
  input  logic          cmp_i,
  output logic [DW-1:0] code_o,
  output srch_mode_e    mode_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o
);

  localparam int            IW       = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [DW-1:0] CODE_MAX = '1;
  localparam logic [IW-1:0] BIT_TOP  = IW'(DW - 1);

  srch_state_e   state_q;
  srch_mode_e    mode_q;
  logic [DW-1:0] code_q, acc_q, result_q;
  logic [IW-1:0] bit_q;
  logic [TW-1:0] timer_q;
  logic          done_q, first_q, ref_q;

  logic [DW-1:0] trial_bit, acc_new;
  logic          is_sar, trk_flip, trk_down;

  always_comb begin
    for (int i = 0; i < DW; i++) trial_bit[i] = (bit_q == IW'(i));
  end

  assign is_sar   = (mode_q == MODE_SAR) || (mode_q == MODE_SAR_X);
  assign acc_new  = cmp_i ? acc_q : code_q;
  assign trk_flip = !first_q && (cmp_i != ref_q);
  assign trk_down = first_q ? cmp_i : ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_STAIR;
      code_q   <= '0;
      acc_q    <= '0;
      result_q <= '0;
      bit_q    <= '0;
      timer_q  <= '0;
      done_q   <= 1'b0;
      first_q  <= 1'b0;
      ref_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q  <= srch_mode_e'(mode_i);
            first_q <= 1'b1;
            unique case (srch_mode_e'(mode_i))
              MODE_STAIR: begin
                code_q  <= '0;
                timer_q <= discharge_i;
                state_q <= ST_DISCH;
              end
              MODE_TRACK: begin
                timer_q <= settle_i;
                state_q <= ST_SETTLE;
              end
              default: begin
                acc_q   <= '0;
                bit_q   <= BIT_TOP;
                code_q  <= {1'b1, {(DW-1){1'b0}}};
                timer_q <= settle_i;
                state_q <= ST_SETTLE;
              end
            endcase
          end
        end
        ST_DISCH: begin
          if (timer_q == '0) begin
            timer_q <= settle_i;
            state_q <= ST_SETTLE;
          end else begin
            timer_q <= timer_q - 1'b1;
          end
        end
        ST_SETTLE: begin
          if (timer_q == '0) state_q <= ST_SAMPLE;
          else               timer_q <= timer_q - 1'b1;
        end
        ST_SAMPLE: begin
          timer_q <= settle_i;
          state_q <= ST_SETTLE;
          first_q <= 1'b0;
          if (first_q) ref_q <= cmp_i;
          if (is_sar) begin
            if (bit_q == '0) begin
              code_q   <= acc_new;
              result_q <= acc_new;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              acc_q  <= acc_new;
              code_q <= acc_new | (trial_bit >> 1);
              bit_q  <= bit_q - 1'b1;
            end
          end else if (mode_q == MODE_STAIR) begin
            if (cmp_i || code_q == CODE_MAX) begin
              result_q <= code_q;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              code_q <= code_q + 1'b1;
            end
          end else begin
            // tracking: stop on reversal or at a bound
            if (trk_flip ||
                (trk_down && code_q == '0) ||
                (!trk_down && code_q == CODE_MAX)) begin
              result_q <= code_q;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (trk_down) begin
              code_q <= code_q - 1'b1;
            end else begin
              code_q <= code_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;

endmodule

// File: rtl/adc_search_ctrl.sv
module adc_search_ctrl
  import adc_search_pkg::*;
#(
  parameter int DW          = 8,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [TW-1:0] settle_i,
  input  logic [TW-1:0] discharge_i,
  input  logic          cmp_i,
  output logic          pwm_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o
);

  logic          cmp_s;
  logic [DW-1:0] dac_code;
  srch_mode_e    mode_q;

  adc_cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (cmp_s)
  );

  adc_search_fsm #(.DW(DW), .TW(TW)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .settle_i    (settle_i),
    .discharge_i (discharge_i),
    .cmp_i       (cmp_s),
    .code_o      (dac_code),
    .mode_o      (mode_q),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o)
  );

  adc_pwm_dac #(.DW(DW)) i_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (dac_code),
    .pwm_o  (pwm_o)
  );

endmodule

// File: rtl/adc_search_chk.sv
module adc_search_chk
  import adc_search_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          done_i,
  input logic [DW-1:0] result_i,
  input logic          pwm_i,
  input logic [DW-1:0] code_i,
  input srch_mode_e    mode_i
);

  assert_pwm_zero_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_i |-> ($past(code_i) != '0));

  assert_stair_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && mode_i == MODE_STAIR && code_i != $past(code_i))
      |-> (code_i == DW'($past(code_i) + 1'b1)));

  assert_track_unit_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && mode_i == MODE_TRACK && code_i != $past(code_i))
      |-> (code_i == DW'($past(code_i) + 1'b1) || code_i == DW'($past(code_i) - 1'b1)));

  assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(mode_i));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_done_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  assert_result_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_i));

endmodule

bind adc_search_ctrl adc_search_chk #(.DW(DW)) i_adc_search_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_o),
  .done_i   (done_o),
  .result_i (result_o),
  .pwm_i    (pwm_o),
  .code_i   (dac_code),
  .mode_i   (mode_q)
);

// File: tb/test_adc_search_ctrl.sv
module test_adc_search_ctrl;

  localparam int DW   = 6;
  localparam int TW   = 16;
  localparam int P    = 1 << DW;
  localparam int MAXC = P - 1;
  localparam int DIS  = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [TW-1:0] settle_i = TW'(P + 4);
  logic [TW-1:0] discharge_i = TW'(DIS);
  logic          cmp_i = 1'b0;
  logic          pwm_o, busy_o, done_o;
  logic [DW-1:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int vin = 0;
  logic [P-1:0] hist = '0;

  always #2.5 clk_i = ~clk_i;

  adc_search_ctrl #(.DW(DW), .TW(TW)) i_adc_search_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .settle_i    (settle_i),
    .discharge_i (discharge_i),
    .cmp_i       (cmp_i),
    .pwm_o       (pwm_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // RC filter + comparator: level = high pulses over last period
  always @(negedge clk_i) begin
    hist  = {hist[P-2:0], pwm_o};
    cmp_i = ($countones(hist) > vin);
  end

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // expected result and cycle count for one conversion
  function automatic void predict(input int mode, input int c, input int v,
                                  input int s, output int res, output int n);
    int k;
    if (mode == 0) begin
      res = min2(v + 1, MAXC);
      k   = res + 1;
      n   = DIS + 1 + k * (s + 2);
    end else if (mode == 1) begin
      if (c > v) begin res = v; k = c - v + 1; end
      else begin res = min2(v + 1, MAXC); k = res - c + 1; end
      n = k * (s + 2);
    end else begin
      res = min2(v, MAXC);
      n   = DW * (s + 2);
    end
  endfunction

  // behavioural reference, advanced every clock
  bit    m_busy = 0, m_done = 0;
  int    m_left = 0, m_code = 0, m_result = 0, m_pend = 0;
  string m_tag = "R7";

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_left = 0; m_code = 0; m_result = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_result = m_pend; m_code = m_pend;
        end
      end else if (start_i) begin
        predict(int'(mode_i), m_code, vin, int'(settle_i), m_pend, m_left);
        m_busy = 1;
        case (mode_i)
          2'd0: m_tag = "R3";
          2'd1: m_tag = "R5";
          2'd2: m_tag = "R6";
          default: m_tag = "R10";
        endcase
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk(busy_o == m_busy, "R7", "busy per clock", busy_o, m_busy);
      chk(done_o == m_done, "R9", "done per clock", done_o, m_done);
      chk(int'(result_o) == m_result, m_tag, "result per clock", result_o, m_result);
    end
  end

  task automatic convert(input int mode, input int v, input string tag);
    int res, n, cyc;
    vin = v;
    predict(mode, m_code, v, int'(settle_i), res, n);
    mode_i = 2'(mode);
    @(negedge clk_i); start_i = 1'b1; cyc = 0;
    @(negedge clk_i); start_i = 1'b0; cyc = 1;
    while (!done_o && cyc < 20000) begin @(negedge clk_i); cyc++; end
    chk(done_o, tag, "done seen", done_o, 1);
    chk(int'(result_o) == res, tag, "result", result_o, res);
    chk(cyc == n + 1, tag, "conversion cycles", cyc, n + 1);
    @(negedge clk_i);
  endtask

  task automatic pwm_count(input int exp);
    int ones = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk_i);
      if (pwm_o) ones++;
    end
    chk(ones == exp, "R2", "pwm high count per period", ones, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk(!busy_o && !done_o, "R1", "busy/done in reset", {busy_o, done_o}, 0);
    chk(result_o == '0, "R1", "result in reset", result_o, 0);
    rst_ni = 1'b1;
    repeat (P + 8) @(negedge clk_i);
    chk(pwm_o == 1'b0, "R1", "pwm idle after reset", pwm_o, 0);
    chk(result_o == '0, "R1", "result after reset", result_o, 0);

    convert(0, 20, "R3");
    pwm_count(21);
    convert(1, 17, "R5");
    convert(1, 30, "R5");
    pwm_count(31);
    convert(2, 42, "R6");
    convert(2, 0, "R6");
    pwm_count(0);
    convert(3, 9, "R10");
    convert(0, 63, "R4");
    convert(1, 63, "R4");
    pwm_count(MAXC);

    // R8: mode change and extra start during a conversion
    begin
      int cyc;
      vin = 5;
      mode_i = 2'd0;
      @(negedge clk_i); start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      repeat (40) @(negedge clk_i);
      mode_i = 2'd2; start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      cyc = 0;
      while (!done_o && cyc < 20000) begin @(negedge clk_i); cyc++; end
      chk(int'(result_o) == 6, "R8", "result with mode changed mid-run", result_o, 6);
      @(negedge clk_i);
      chk(!busy_o, "R8", "extra start ignored", busy_o, 0);
    end

    // R7: longer settle stretches every step
    settle_i = TW'(P + 26);
    repeat (4) @(negedge clk_i);
    convert(2, 50, "R7");
    pwm_count(50);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule